// File: doc/BRIEF.md
# Speed-Line Boot Phase Sequencer

This block follows the start-up of an optical-disc drive by watching one status line that reports whether the drive spins at single or double speed, together with a reset-event input and a lid-closed event input. It does not turn its output on and off from the speed level. Audio playback also runs at single speed, so a level gate would open at the wrong times. Instead the block runs an ordered series of timed phases and treats speed changes only as hints of where the start-up has got to. Its single enable output tells a separate low-rate serial string generator when it may transmit.

A reset event or a lid-closed event starts the series. Each has its own start delay. The block then waits for single speed, which opens the first window. It waits for double speed again and runs a fixed gap timer. The next single-speed period opens the second window. After the second window closes, the block stays idle until the lid is closed again. Every input is synchronised with two flip-flops. A speed change counts only once it has held for a set number of clocks. Each waiting phase has a timeout that returns the block to idle.

Top module: `speed_phase_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `phase_dbg` is 0 (idle) and `inject_en` is 0.
- R2: A rising edge on `reset_evt_in` moves the block to the start-delay phase (`phase_dbg` = 1). The phase lasts `rst_delay`+1 clocks and then moves to the first seek phase (`phase_dbg` = 2).
- R3: A rising edge on `door_evt_in` also enters the start-delay phase, but for `door_delay`+1 clocks, before the first seek phase.
- R4: In the first seek phase, a filtered speed of single (`speed_in` = 0) opens the first window (`phase_dbg` = 3), and `inject_en` goes to 1.
- R5: In the first window, a filtered speed of double (`speed_in` = 1) enters the gap phase (`phase_dbg` = 4). The gap phase lasts `gap_time`+1 clocks, whatever the speed line does, and then enters the second seek phase (`phase_dbg` = 5).
- R6: In the second seek phase, single speed opens the second window (`phase_dbg` = 6, `inject_en` = 1). A return to double speed then takes the block to idle (`phase_dbg` = 0).
- R7: In idle, speed changes have no effect: `phase_dbg` stays 0 and `inject_en` stays 0 until a reset or lid event.
- R8: A speed level that differs from the accepted level for fewer than `STABLE_CLKS` consecutive clocks after synchronisation is ignored.
- R9: If a seek phase or a window phase stays unresolved for more than `wait_limit`+1 clocks, the block returns to idle with `inject_en` at 0.
- R10: A reset event restarts the sequence from any phase with the reset delay. If a reset event and a lid event arrive in the same clock, the reset event wins.
- R11: `inject_en` is 1 exactly when `phase_dbg` is 3 or 6, and it changes in the same clock as the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_in | input | 1 | Drive speed status, 1 = double, 0 = single (asynchronous) |
| reset_evt_in | input | 1 | Reset event, active on its rising edge (asynchronous) |
| door_evt_in | input | 1 | Lid-closed event, active on its rising edge (asynchronous) |
| rst_delay | input | CW | Start delay after a reset event, in clocks minus one |
| door_delay | input | CW | Start delay after a lid event, in clocks minus one |
| gap_time | input | CW | Gap timer length between the two windows, in clocks minus one |
| wait_limit | input | CW | Timeout of each seek and window phase, in clocks minus one |
| inject_en | output | 1 | Transmit permission for the serial string generator |
| phase_dbg | output | 3 | Current phase code, 0 to 6 |

## Verification
The bench builds the block with the default `CW` = 8 and `STABLE_CLKS` = 4. It drives the delays as 20 for a reset event, 40 for a lid event, a 30-clock gap and a 60-clock timeout. These short values let one run reach both windows, the end of the gap timer and a timeout, and the reset and lid delays differ enough to tell them apart from the phase alone. With a four-clock filter, a two-clock speed glitch falls inside the rejection window and can be tested at the ports.

// File: rtl/spd_seq_pkg.sv
package spd_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_SEEK1 = 3'd2,
        PH_WIN1  = 3'd3,
        PH_GAP   = 3'd4,
        PH_SEEK2 = 3'd5,
        PH_WIN2  = 3'd6
    } phase_t;

    // Conditioned inputs handed to the phase machine
    typedef struct packed {
        logic dbl;       // filtered speed, 1 = double
        logic hard_evt;  // one-clock reset event
        logic lid_evt;   // one-clock lid event
    } cue_t;

    function automatic logic in_window(phase_t p);
        return (p == PH_WIN1) || (p == PH_WIN2);
    endfunction

    function automatic logic is_waiting(phase_t p);
        return (p == PH_SEEK1) || (p == PH_WIN1) ||
               (p == PH_SEEK2) || (p == PH_WIN2);
    endfunction

endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic ff1, ff2;
        always_ff @(posedge clk) begin
            if (rst) begin
                ff1 <= RST_VAL[i];
                ff2 <= RST_VAL[i];
            end else begin
                ff1 <= d[i];
                ff2 <= ff1;
            end
        end
        assign q[i] = ff2;
    end
endmodule

// File: rtl/spd_evt_edge.sv
module spd_evt_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;

    // R10
    evt_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/spd_deglitch.sv
module spd_deglitch #(
    parameter int STABLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNTW = (STABLE_CLKS > 1) ? $clog2(STABLE_CLKS) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(STABLE_CLKS - 1);

    logic [CNTW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_o <= 1'b1;
            run    <= '0;
        end else if (raw_i == filt_o) begin
            run <= '0;
        end else if (run == LAST) begin
            filt_o <= raw_i;
            run    <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R8
    filt_follows_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_o != $past(filt_o)) |-> ($past(raw_i) == filt_o));
endmodule

// File: rtl/spd_phase_fsm.sv
module spd_phase_fsm
    import spd_seq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  cue_t          cue,
    input  logic [CW-1:0] rst_delay,
    input  logic [CW-1:0] door_delay,
    input  logic [CW-1:0] gap_time,
    input  logic [CW-1:0] wait_limit,
    output phase_t        phase,
    output logic          inject
);
    phase_t        st, nxt;
    logic [CW-1:0] cnt, ncnt;
    logic          cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_comb begin
        nxt  = st;
        ncnt = cnt;
        if (cue.hard_evt) begin
            nxt  = PH_START;
            ncnt = rst_delay;
        end else if (cue.lid_evt) begin
            nxt  = PH_START;
            ncnt = door_delay;
        end else begin
            unique case (st)
                PH_IDLE: ;
                PH_START, PH_GAP: begin
                    if (cnt_zero) begin
                        nxt  = (st == PH_START) ? PH_SEEK1 : PH_SEEK2;
                        ncnt = wait_limit;
                    end else begin
                        ncnt = cnt - 1'b1;
                    end
                end
                PH_SEEK1, PH_SEEK2: begin
                    if (!cue.dbl) begin
                        nxt  = (st == PH_SEEK1) ? PH_WIN1 : PH_WIN2;
                        ncnt = wait_limit;
                    end else if (cnt_zero) begin
                        nxt = PH_IDLE;
                    end else begin
                        ncnt = cnt - 1'b1;
                    end
                end
                PH_WIN1: begin
                    if (cue.dbl) begin
                        nxt  = PH_GAP;
                        ncnt = gap_time;
                    end else if (cnt_zero) begin
                        nxt = PH_IDLE;
                    end else begin
                        ncnt = cnt - 1'b1;
                    end
                end
                PH_WIN2: begin
                    if (cue.dbl || cnt_zero) nxt = PH_IDLE;
                    else                     ncnt = cnt - 1'b1;
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= ncnt;
        end
    end

    assign phase  = st;
    assign inject = in_window(st);

    // R10
    hard_evt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        cue.hard_evt |=> (st == PH_START && cnt == $past(rst_delay)));

    // R11
    inject_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inject) |-> ($past(st) == PH_SEEK1 || $past(st) == PH_SEEK2));

    // R9
    timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (is_waiting(st) && cnt_zero && !cue.hard_evt && !cue.lid_evt &&
         (st == PH_SEEK1 || st == PH_SEEK2) && cue.dbl) |=> (st == PH_IDLE && !inject));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PH_IDLE && !cue.hard_evt && !cue.lid_evt) |=> (st == PH_IDLE));

    // R5
    gap_ignores_speed_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PH_GAP && !cnt_zero && !cue.hard_evt && !cue.lid_evt) |=> (st == PH_GAP));
endmodule

// File: rtl/speed_phase_seq.sv
module speed_phase_seq
    import spd_seq_pkg::*;
#(
    parameter int CW          = 8,
    parameter int STABLE_CLKS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          speed_in,
    input  logic          reset_evt_in,
    input  logic          door_evt_in,
    input  logic [CW-1:0] rst_delay,
    input  logic [CW-1:0] door_delay,
    input  logic [CW-1:0] gap_time,
    input  logic [CW-1:0] wait_limit,
    output logic          inject_en,
    output logic [2:0]    phase_dbg
);
    logic [2:0] synced;
    logic [1:0] evt_rise;
    logic       dbl_filt;
    cue_t       cue;
    phase_t     phase;

    // bit 2 = speed (resets to double), bit 1 = reset event, bit 0 = lid event
    spd_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({speed_in, reset_evt_in, door_evt_in}),
        .q   (synced)
    );

    spd_evt_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (synced[1:0]),
        .rise (evt_rise)
    );

    spd_deglitch #(.STABLE_CLKS(STABLE_CLKS)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (synced[2]),
        .filt_o (dbl_filt)
    );

    assign cue = '{dbl: dbl_filt, hard_evt: evt_rise[1], lid_evt: evt_rise[0]};

    spd_phase_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cue        (cue),
        .rst_delay  (rst_delay),
        .door_delay (door_delay),
        .gap_time   (gap_time),
        .wait_limit (wait_limit),
        .phase      (phase),
        .inject     (inject_en)
    );

    assign phase_dbg = phase;
endmodule

// File: tb/tb_speed_phase_seq.sv
module tb_speed_phase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          speed_in = 1'b1;
    logic          reset_evt_in = 1'b0;
    logic          door_evt_in = 1'b0;
    logic [CW-1:0] rst_delay  = 8'd20;
    logic [CW-1:0] door_delay = 8'd40;
    logic [CW-1:0] gap_time   = 8'd30;
    logic [CW-1:0] wait_limit = 8'd60;
    logic          inject_en;
    logic [2:0]    phase_dbg;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    speed_phase_seq #(.CW(CW), .STABLE_CLKS(4)) dut (
        .clk (clk), .rst (rst), .speed_in (speed_in),
        .reset_evt_in (reset_evt_in), .door_evt_in (door_evt_in),
        .rst_delay (rst_delay), .door_delay (door_delay),
        .gap_time (gap_time), .wait_limit (wait_limit),
        .inject_en (inject_en), .phase_dbg (phase_dbg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks the phase and, per R11, that inject_en is 1 only for phases 3 and 6
    task automatic expect_phase(input string tag, input logic [2:0] exp);
        logic exp_inj;
        exp_inj = (exp == 3'd3) || (exp == 3'd6);
        n_vec++;
        if (phase_dbg !== exp) begin
            n_bad++;
            $display("FAIL %s phase: actual %0d expected %0d", tag, phase_dbg, exp);
        end
        n_vec++;
        if (inject_en !== exp_inj) begin
            n_bad++;
            $display("FAIL %s R11 inject_en: actual %0b expected %0b", tag, inject_en, exp_inj);
        end
    endtask

    task automatic chip_reset();
        rst = 1'b1; speed_in = 1'b1; reset_evt_in = 1'b0; door_evt_in = 1'b0;
        tick(3);
        expect_phase("R1 in reset", 3'd0);
        rst = 1'b0;
        tick(1);
        expect_phase("R1 after release", 3'd0);
        tick(4);
    endtask

    task automatic pulse_evt(input logic do_rst, input logic do_door);
        reset_evt_in = do_rst; door_evt_in = do_door;
        tick(2);
        reset_evt_in = 1'b0; door_evt_in = 1'b0;
    endtask

    task automatic t_full_sequence();
        chip_reset();
        pulse_evt(1'b1, 1'b0);            // t=2
        tick(3);  expect_phase("R2 start delay", 3'd1);     // t=5
        tick(15); expect_phase("R2 still delaying", 3'd1);  // t=20, leaves at 24
        tick(10); expect_phase("R2 first seek", 3'd2);      // t=30
        speed_in = 1'b0;
        tick(10); expect_phase("R4 first window", 3'd3);    // t=40
        speed_in = 1'b1;
        tick(10); expect_phase("R5 gap entered", 3'd4);     // t=50, gap from 47 to 78
        tick(2);  speed_in = 1'b0;
        tick(8);  speed_in = 1'b1;
        tick(10); expect_phase("R5 gap ignores speed", 3'd4); // t=70
        tick(15); expect_phase("R5 second seek", 3'd5);     // t=85
        speed_in = 1'b0;
        tick(10); expect_phase("R6 second window", 3'd6);
        speed_in = 1'b1;
        tick(10); expect_phase("R6 back to idle", 3'd0);
        speed_in = 1'b0;
        tick(20); expect_phase("R7 idle ignores single", 3'd0);
        speed_in = 1'b1;
        tick(20); expect_phase("R7 idle ignores double", 3'd0);
    endtask

    task automatic t_door_delay();
        chip_reset();
        pulse_evt(1'b0, 1'b1);
        tick(3);  expect_phase("R3 door start", 3'd1);
        tick(25); expect_phase("R3 longer door delay", 3'd1); // t=30, leaves at 44
        tick(20); expect_phase("R3 first seek", 3'd2);        // t=50
    endtask

    task automatic t_glitch_timeout();
        chip_reset();
        pulse_evt(1'b1, 1'b0);
        tick(28); expect_phase("R2 seek before glitch", 3'd2); // t=30
        speed_in = 1'b0;
        tick(2);  speed_in = 1'b1;
        tick(10); expect_phase("R8 glitch ignored", 3'd2);     // t=42
        tick(50); expect_phase("R9 seek timeout", 3'd0);       // t=92, timeout at 85
    endtask

    task automatic t_priority();
        chip_reset();
        pulse_evt(1'b1, 1'b1);
        tick(28); expect_phase("R10 reset beats door", 3'd2);  // t=30, door would still delay
        speed_in = 1'b0;
        tick(10); expect_phase("R4 window before restart", 3'd3);
        pulse_evt(1'b1, 1'b0);
        tick(3);  expect_phase("R10 restart from window", 3'd1);
        tick(12); expect_phase("R10 reset delay again", 3'd1);
        speed_in = 1'b1;
        tick(20);
    endtask

    task automatic t_window_timeout();
        chip_reset();
        pulse_evt(1'b1, 1'b0);
        tick(28);
        speed_in = 1'b0;                                        // window opens at 37
        tick(10); expect_phase("R4 window open", 3'd3);        // t=40
        tick(60); expect_phase("R9 window timeout", 3'd0);     // t=100, timeout at 98
        speed_in = 1'b1;
        tick(10);
        pulse_evt(1'b0, 1'b1);
        tick(3);  expect_phase("R3 door restarts idle", 3'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(1);
        t_full_sequence();
        t_door_delay();
        t_glitch_timeout();
        t_priority();
        t_window_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule